// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a stream of compressed code bytes into the serial bit stream that a programmable device loads during configuration. Code bytes arrive on a valid/ready byte port. Each one expands into a run of identical bits, which may be followed by one terminating bit of the opposite value. The bits leave on a valid/ready single-bit port. A parameter sets where the code table splits between runs of ones and runs of zeros.

After reset, and again after every start pulse, the block first sends a fixed 16-bit header. It accepts no code byte until the header has gone out. Back-pressure works on both sides. A stalled output bit stays unchanged. A new code byte is taken only once every bit of the previous expansion has been accepted downstream. The busy output stays high while any header or expansion bit is still waiting to be sent.

Top module: `rle_bit_expander`

## Requirements
- R1: After reset, and one cycle after a start pulse, the block sends the 16-bit header 1111111100100000 (0xFF then 0x20, most significant bit first) before any expansion bit. code_ready stays low for the whole header.
- R2: A code n with 1 <= n <= MAX_ONES (default 226) sends n one-bits and then a single zero-bit.
- R3: Code MAX_ONES+1 sends MAX_ONES one-bits and no terminating bit.
- R4: A code n with MAX_ONES+2 <= n <= 254 sends n-(MAX_ONES+2) zero-bits and then a single one-bit. Code MAX_ONES+2 therefore sends only the one-bit.
- R5: Code 255 sends exactly one one-bit.
- R6: Code 0 is consumed in a single handshake and sends no bits.
- R7: code_ready is high only when no bit is pending and start is low. A new code is therefore taken only after the last bit of the previous expansion has been accepted.
- R8: While bit_valid is high and bit_ready is low, and start is low, bit_valid and bit_data hold their values into the next cycle.
- R9: A start pulse discards any unsent expansion bits and restarts the header. In the cycle where start is high, no code byte is accepted, even if a bit handshake happens in that same cycle.
- R10: busy is high exactly while at least one header or expansion bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; arms the header |
| start | input | 1 | One-cycle pulse that re-arms the header and drops the current run |
| code_valid | input | 1 | A code byte is offered |
| code_data | input | 8 | Compressed code byte |
| code_ready | output | 1 | The block takes the offered code byte this cycle |
| bit_valid | output | 1 | An output bit is offered |
| bit_data | output | 1 | Output bit value |
| bit_ready | input | 1 | Downstream accepts the offered bit |
| busy | output | 1 | Header or expansion bits are still pending |

## Verification
Two events can land in the same cycle and compete. The first is a start pulse arriving together with a bit handshake in the middle of a run. The second is a start pulse arriving while a code byte is offered to an idle block. The bench drives start high in the same cycle as bit_ready, and separately in the same cycle as code_valid. In the first case it expects the full header and then no leftover run bits. In the second it expects code_ready to be low in that cycle, the header to follow, and only then the offered code's expansion.

// File: rtl/rle_bit_expander.sv
module rle_bit_expander #(
  parameter int MAX_ONES = 226
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       code_valid,
  input  logic [7:0] code_data,
  output logic       code_ready,
  output logic       bit_valid,
  output logic       bit_data,
  input  logic       bit_ready,
  output logic       busy
);
  localparam int HDR_LEN = 16;
  localparam logic [HDR_LEN-1:0] HDR = 16'hFF20;
  localparam int LONG_CODE = MAX_ONES + 1;
  localparam int ZERO_BASE = MAX_ONES + 2;

  logic [4:0] hdr_left;
  logic [7:0] run_left;
  logic       run_bit;
  logic       tail_pend;
  logic       tail_bit;

  wire hdr_on = hdr_left != 5'd0;
  wire run_on = run_left != 8'd0;
  wire [3:0] hdr_idx = 4'(hdr_left - 5'd1);
  wire take_code = code_valid && code_ready;
  wire take_bit  = bit_valid && bit_ready;

  assign bit_valid  = hdr_on || run_on || tail_pend;
  assign bit_data   = hdr_on ? HDR[hdr_idx] : (run_on ? run_bit : tail_bit);
  assign code_ready = !bit_valid && !start;
  assign busy       = bit_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      hdr_left  <= 5'(HDR_LEN);
      run_left  <= '0;
      tail_pend <= 1'b0;
      if (!rst_n) begin
        run_bit  <= 1'b0;
        tail_bit <= 1'b0;
      end
    end else begin
      if (take_bit) begin
        if (hdr_on)      hdr_left  <= hdr_left - 5'd1;
        else if (run_on) run_left  <= run_left - 8'd1;
        else             tail_pend <= 1'b0;
      end
      if (take_code) begin
        if (code_data == 8'd0) begin
          run_left  <= '0;
          tail_pend <= 1'b0;
        end else if (code_data <= 8'(MAX_ONES)) begin
          run_left  <= code_data;
          run_bit   <= 1'b1;
          tail_pend <= 1'b1;
          tail_bit  <= 1'b0;
        end else if (code_data == 8'(LONG_CODE)) begin
          run_left  <= 8'(MAX_ONES);
          run_bit   <= 1'b1;
          tail_pend <= 1'b0;
        end else if (code_data == 8'd255) begin
          run_left  <= '0;
          tail_pend <= 1'b1;
          tail_bit  <= 1'b1;
        end else begin
          run_left  <= code_data - 8'(ZERO_BASE);
          run_bit   <= 1'b0;
          tail_pend <= 1'b1;
          tail_bit  <= 1'b1;
        end
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready && !start) |=> (bit_valid && $stable(bit_data)));

  assert_header_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bit_valid && bit_data && !code_ready));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (hdr_left == 5'(HDR_LEN)));

  assert_zero_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_ready && code_data == 8'd0) |=> !busy);

  assert_code_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_ready && code_data != 8'd0) |=> busy);

  assert_one_at_a_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> !code_ready);
endmodule

// File: tb/rle_bit_expander_test.sv
module rle_bit_expander_test;
  localparam int M = 226;
  localparam logic [15:0] HDR_EXP = 16'hFF20;
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'd1},   {1'b1, 8'd5},   {1'b0, 8'd226}, {1'b0, 8'd227},
    {1'b0, 8'd228}, {1'b1, 8'd240}, {1'b0, 8'd254}, {1'b0, 8'd255},
    {1'b0, 8'd0},   {1'b1, 8'd2},   {1'b1, 8'd255}, {1'b0, 8'd0},
    {1'b0, 8'd100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic code_valid = 1'b0;
  logic [7:0] code_data = 8'd0;
  logic code_ready, bit_valid, bit_data, busy;
  logic bit_ready = 1'b0;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rle_bit_expander #(.MAX_ONES(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_valid(code_valid),
    .code_data(code_data), .code_ready(code_ready), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic take_bit(input bit exp, input bit stall, input string req);
    logic held;
    if (stall) begin
      bit_ready = 1'b0;
      held = bit_data;
      @(negedge clk);
      check(bit_valid && bit_data == held, "R8", int'(bit_data), int'(held));
    end
    check(bit_valid == 1'b1, req, int'(bit_valid), 1);
    check(bit_data == exp, req, int'(bit_data), int'(exp));
    check(busy == 1'b1, "R10", int'(busy), 1);
    check(code_ready == 1'b0, "R7", int'(code_ready), 0);
    bit_ready = 1'b1;
    @(negedge clk);
    bit_ready = 1'b0;
  endtask

  task automatic take_header();
    for (int i = 15; i >= 0; i--) take_bit(HDR_EXP[i], 1'b0, "R1");
  endtask

  task automatic put_code(input logic [7:0] c);
    code_valid = 1'b1;
    code_data = c;
    while (!code_ready) @(negedge clk);
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  task automatic expand(input logic [7:0] c, input bit stall);
    int n; bit v; bit has_t; bit tv; string req;
    n = 0; v = 1'b0; has_t = 1'b0; tv = 1'b0; req = "R6";
    if (c >= 1 && c <= M) begin n = c; v = 1'b1; has_t = 1'b1; tv = 1'b0; req = "R2"; end
    else if (c == M + 1) begin n = M; v = 1'b1; req = "R3"; end
    else if (c >= M + 2 && c <= 254) begin n = c - (M + 2); v = 1'b0; has_t = 1'b1; tv = 1'b1; req = "R4"; end
    else if (c == 255) begin has_t = 1'b1; tv = 1'b1; req = "R5"; end
    for (int k = 0; k < n; k++) take_bit(v, stall && (k == 0), req);
    if (has_t) take_bit(tv, stall, req);
    check(bit_valid == 1'b0, req, int'(bit_valid), 0);
    check(busy == 1'b0, "R10", int'(busy), 0);
    check(code_ready == 1'b1, "R7", int'(code_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(bit_valid == 1'b1 && bit_data == 1'b1, "R1", int'(bit_valid), 1);
    check(code_ready == 1'b0, "R1", int'(code_ready), 0);
    check(busy == 1'b1, "R10", int'(busy), 1);
    code_valid = 1'b1; code_data = 8'd3;
    take_header();
    code_valid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      put_code(VEC[i][7:0]);
      expand(VEC[i][7:0], VEC[i][8]);
    end

    // R9: start together with a bit handshake mid-run
    put_code(8'd10);
    take_bit(1'b1, 1'b0, "R2");
    take_bit(1'b1, 1'b0, "R2");
    start = 1'b1; bit_ready = 1'b1;
    @(negedge clk);
    start = 1'b0; bit_ready = 1'b0;
    take_header();
    check(bit_valid == 1'b0, "R9", int'(bit_valid), 0);
    check(busy == 1'b0, "R9", int'(busy), 0);

    // R9: start together with a code offer on an idle block
    code_valid = 1'b1; code_data = 8'd4; start = 1'b1;
    #1;
    check(code_ready == 1'b0, "R9", int'(code_ready), 0);
    @(negedge clk);
    start = 1'b0;
    take_header();
    put_code(8'd4);
    expand(8'd4, 1'b0);

    // R4 boundary: MAX_ONES+2 gives only a one, then R6 zero code
    put_code(8'(M + 2));
    expand(8'(M + 2), 1'b1);
    put_code(8'd0);
    check(bit_valid == 1'b0, "R6", int'(bit_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule